// File: doc/BRIEF.md
# Bounded Signed Adder with Clip Flags

This block adds two signed two's-complement operands and limits the result to a window. The window is given by a lower bound and an upper bound, and both bounds are inputs that may change on any cycle. They are not tied to the numeric range of the output type. The sum is formed one bit wider than the operands, so the comparison against the bounds always sees the true value and never a wrapped one.

A two-bit flag vector reports which side of the window the true sum fell on. The typical users are control loops and filters that must keep an actuator word inside a range set by software. When the bounds are inverted (upper below lower), a sum that lies strictly between them meets both conditions at once. In that case the result is forced to zero.

By default the block is purely combinational. A parameter inserts one output register stage with a synchronous reset.

Top module: `satclamp_adder`

## Requirements
- R1: Operands, bounds and result are signed two's-complement values of width W. The sum is evaluated at W+1 bits without wrap. For example, at W=4, 7+7 with upper bound 7 yields 7 with the upper flag set; it never yields a negative wrapped value.
- R2: When the true sum is below the lower bound and not above the upper bound, the result equals the lower bound and the clip vector is 2'b01 (bit 0 means below the lower bound).
- R3: When the true sum is above the upper bound and not below the lower bound, the result equals the upper bound and the clip vector is 2'b10 (bit 1 means above the upper bound).
- R4: When the true sum is both above the upper bound and below the lower bound (inverted bounds), the result is zero and the clip vector is 2'b11.
- R5: When the true sum lies within the bounds inclusive, the result equals the sum and the clip vector is 2'b00.
- R6: With REG_OUT=0, the result and the clip vector follow the inputs within the same cycle, and the reset input has no effect on them.
- R7: With REG_OUT=1, the result and the clip vector on the outputs are those for the inputs sampled at the preceding rising clock edge.
- R8: With REG_OUT=1, a rising edge with the synchronous active-high reset asserted clears the result and the clip vector to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage and the checks |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| op_a | input | W | First signed operand |
| op_b | input | W | Second signed operand |
| lim_lo | input | W | Signed lower bound |
| lim_hi | input | W | Signed upper bound |
| sum_o | output | W | Bounded signed result |
| clip_o | output | 2 | Bit 0: sum below lower bound; bit 1: sum above upper bound |

## Verification
At W=4, every operand pair is swept for each bound pair drawn from {-8, 0, 1, 7}. That set covers equal bounds, the full type range, bounds at the type extremes and inverted bounds. The sweep separates a wrapped sum from a widened one (R1), and it separates each clamp branch and the inverted-zero case. Fully random operands and bounds follow, to reach bound pairs that the sweep does not hit. Two instances, one combinational and one registered, take the same stimulus. Comparing them shows the one-cycle lag, and asserting reset mid-run shows that the registered copy clears while the combinational copy does not.

// File: rtl/satclamp_pkg.sv
package satclamp_pkg;

    // Clip flags: packed so that {above, below} is the 2-bit port vector.
    typedef struct packed {
        logic above;   // bit 1
        logic below;   // bit 0
    } clip_flags_t;

    localparam int CLIP_W = 2;

endpackage

// File: rtl/satclamp_sum.sv
module satclamp_sum #(
    parameter int W = 16
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W:0]   sum_wide
);
    localparam int SW = W + 1;

    logic [SW-1:0] a_ext;
    logic [SW-1:0] b_ext;

    always_comb begin
        a_ext    = {op_a[W-1], op_a};
        b_ext    = {op_b[W-1], op_b};
        sum_wide = a_ext + b_ext;
    end

endmodule

// File: rtl/satclamp_cmp.sv
module satclamp_cmp
    import satclamp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W:0]   sum_wide,
    input  logic [W-1:0] lim_lo,
    input  logic [W-1:0] lim_hi,
    output clip_flags_t  flags
);
    localparam int SW = W + 1;

    logic signed [SW-1:0] lo_ext;
    logic signed [SW-1:0] hi_ext;
    logic signed [SW-1:0] s_sgn;

    always_comb begin
        lo_ext      = $signed({lim_lo[W-1], lim_lo});
        hi_ext      = $signed({lim_hi[W-1], lim_hi});
        s_sgn       = $signed(sum_wide);
        flags.below = (s_sgn < lo_ext);
        flags.above = (s_sgn > hi_ext);
    end

endmodule

// File: rtl/satclamp_select.sv
module satclamp_select
    import satclamp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W:0]   sum_wide,
    input  logic [W-1:0] lim_lo,
    input  logic [W-1:0] lim_hi,
    input  clip_flags_t  flags,
    output logic [W-1:0] result
);

    always_comb begin
        unique case (flags)
            2'b11:   result = '0;
            2'b01:   result = lim_lo;
            2'b10:   result = lim_hi;
            default: result = sum_wide[W-1:0];
        endcase
    end

    AST_LOW_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (flags == 2'b01) |-> (result == lim_lo)); // R2

    AST_HIGH_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (flags == 2'b10) |-> (result == lim_hi)); // R3

    AST_INVERTED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (flags == 2'b11) |-> ((result == '0) && ($signed(lim_hi) < $signed(lim_lo)))); // R4

    AST_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (flags == 2'b00) |-> (($signed(result) >= $signed(lim_lo)) && ($signed(result) <= $signed(lim_hi)))); // R5

endmodule

// File: rtl/satclamp_outreg.sv
module satclamp_outreg
    import satclamp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      res_in,
    input  logic [CLIP_W-1:0] clip_in,
    output logic [W-1:0]      res_out,
    output logic [CLIP_W-1:0] clip_out
);
    typedef struct packed {
        logic [W-1:0]      res;
        logic [CLIP_W-1:0] clip;
    } stage_t;

    stage_t stage_d;
    stage_t stage_q;

    always_comb begin
        stage_d.res  = res_in;
        stage_d.clip = clip_in;
        if (rst) begin
            stage_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        stage_q <= stage_d;
    end

    assign res_out  = stage_q.res;
    assign clip_out = stage_q.clip;

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((res_out == '0) && (clip_out == '0))); // R8

endmodule

// File: rtl/satclamp_adder.sv
module satclamp_adder
    import satclamp_pkg::*;
#(
    parameter int W       = 16,
    parameter bit REG_OUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic [W-1:0]      lim_lo,
    input  logic [W-1:0]      lim_hi,
    output logic [W-1:0]      sum_o,
    output logic [CLIP_W-1:0] clip_o
);
    logic [W:0]   sum_wide;
    clip_flags_t  flags;
    logic [W-1:0] result;

    satclamp_sum #(.W(W)) sum_i (
        .op_a     (op_a),
        .op_b     (op_b),
        .sum_wide (sum_wide)
    );

    satclamp_cmp #(.W(W)) cmp_i (
        .sum_wide (sum_wide),
        .lim_lo   (lim_lo),
        .lim_hi   (lim_hi),
        .flags    (flags)
    );

    satclamp_select #(.W(W)) sel_i (
        .clk      (clk),
        .rst      (rst),
        .sum_wide (sum_wide),
        .lim_lo   (lim_lo),
        .lim_hi   (lim_hi),
        .flags    (flags),
        .result   (result)
    );

    generate
        if (REG_OUT) begin : g_reg
            satclamp_outreg #(.W(W)) oreg_i (
                .clk      (clk),
                .rst      (rst),
                .res_in   (result),
                .clip_in  (flags),
                .res_out  (sum_o),
                .clip_out (clip_o)
            );
        end else begin : g_comb
            assign sum_o  = result;
            assign clip_o = flags;
        end
    endgenerate

endmodule

// File: tb/satclamp_adder_tb.sv
`timescale 1ns/1ps
module satclamp_adder_tb_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0, op_b = '0, lim_lo = '0, lim_hi = '0;
    logic [W-1:0] c_sum, r_sum;
    logic [1:0]   c_clip, r_clip;

    int n_chk  = 0;
    int n_fail = 0;

    bit    prev_ok = 0;
    int    prev_res, prev_clip;
    string prev_tag;

    always #4 clk = ~clk;

    satclamp_adder #(.W(W), .REG_OUT(1'b0)) dut_i (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
        .lim_lo(lim_lo), .lim_hi(lim_hi), .sum_o(c_sum), .clip_o(c_clip));

    satclamp_adder #(.W(W), .REG_OUT(1'b1)) dut_reg_i (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
        .lim_lo(lim_lo), .lim_hi(lim_hi), .sum_o(r_sum), .clip_o(r_clip));

    function automatic int sx(int v);
        logic [W-1:0] t;
        t = v[W-1:0];
        return int'($signed(t));
    endfunction

    function automatic int ref_clip(int a, int b, int lo, int hi);
        int full;
        full = a + b;
        return ((full > hi) ? 2 : 0) | ((full < lo) ? 1 : 0);
    endfunction

    function automatic int ref_res(int a, int b, int lo, int hi);
        int full;
        full = a + b;
        if (full < lo && full > hi) return 0;
        if (full < lo) return lo;
        if (full > hi) return hi;
        return full;
    endfunction

    function automatic string tag_of(int clip);
        case (clip)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic apply(int a, int b, int lo, int hi);
        int er, ec;
        string t;
        @(negedge clk);
        if (prev_ok) begin
            chk({"R7 registered result ", prev_tag}, sx(int'(r_sum)), prev_res);
            chk({"R7 registered clip ", prev_tag}, int'(r_clip), prev_clip);
        end
        op_a = a[W-1:0]; op_b = b[W-1:0]; lim_lo = lo[W-1:0]; lim_hi = hi[W-1:0];
        #1;
        er = ref_res(a, b, lo, hi);
        ec = ref_clip(a, b, lo, hi);
        t  = tag_of(ec);
        chk({"R6 comb result ", t}, sx(int'(c_sum)), er);
        chk({"R6 comb clip ", t}, int'(c_clip), ec);
        prev_ok = 1; prev_res = er; prev_clip = ec; prev_tag = t;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int lims[4] = '{-8, 0, 1, 7};
        void'($urandom(32'd20240611));

        // Reset state: registered copy cleared, combinational copy live (R8, R6)
        @(negedge clk);
        op_a = 4'sd3; op_b = 4'sd2; lim_lo = -4'sd8; lim_hi = 4'sd7;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R8 reset result", int'(r_sum), 0);
        chk("R8 reset clip", int'(r_clip), 0);
        chk("R6 comb under reset", sx(int'(c_sum)), 5);
        rst = 1'b0;

        // Directed: widened sum, no wrap (R1)
        apply(7, 7, -8, 7);
        chk("R1 no wrap high", sx(int'(c_sum)), 7);
        apply(-8, -8, -8, 7);
        chk("R1 no wrap low", int'(c_clip), 1);
        apply(7, 1, -8, 7);
        chk("R1 upper flag at +8", int'(c_clip), 2);

        // Exhaustive sweep over bound pairs
        foreach (lims[i]) begin
            foreach (lims[j]) begin
                for (int a = -8; a < 8; a++) begin
                    for (int b = -8; b < 8; b++) begin
                        apply(a, b, lims[i], lims[j]);
                    end
                end
            end
        end

        // Random operands and bounds
        for (int k = 0; k < 1500; k++) begin
            apply(sx(int'($urandom)), sx(int'($urandom)), sx(int'($urandom)), sx(int'($urandom)));
        end

        // Mid-run reset with a nonzero pending value (R8)
        apply(3, 3, -8, 7);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R8 mid-run reset result", int'(r_sum), 0);
        chk("R8 mid-run reset clip", int'(r_clip), 0);
        chk("R6 comb ignores reset", sx(int'(c_sum)), 6);
        rst = 1'b0;
        prev_ok = 0;
        apply(-3, -3, 0, 7);
        apply(2, 2, 7, 0);
        apply(0, 0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule